// File: doc/BRIEF.md
# Ambisonic Encode-Sum-Decode Pipeline

This block spatialises four mono sources for a loudspeaker array. At each sample period it takes one 16-bit sample per input channel. It expands each sample into a 16-component third-order ambisonic vector. Component 0 is the sample itself, and the other fifteen are the sample scaled by per-channel spherical-harmonic gains. The four vectors are added into one sound-field vector. That field is then projected onto eight per-speaker weight vectors, which gives one output sample per loudspeaker.

The stages are not a free-running stream. A sample pulse from the output side captures the new input samples, drops every stage's valid flag and restarts the chain. The coefficient stage goes valid first. Each encoder then runs, and when all encoders are done the summer runs. When the field is ready the decoders run. At the next pulse the finished speaker samples are moved to the output register. If the decoders have not finished by then, the old outputs stay and an underrun flag is raised. Gains and weights come in through a write-only register port. Each encoder and each decoder uses one shared multiplier, stepped over 16 cycles, so the sample period must be well above the chain latency of about 35 cycles.

Top module: `ambi_pipeline`

## Requirements
- R1: After reset, `spk_out` is all zeros and `underrun` is 0.
- R2: Encoding. For channel c, component 0 equals the sample. Component k (1..15) equals the sample times gain, arithmetically shifted right by 15 and saturated to 16 bits. The gain is written at address c*16+k. Writes to address c*16+0 are ignored.
- R3: Field component k is the sum over the four channels of their component k, saturated to the signed 16-bit range.
- R4: Speaker s outputs (sum over k of field[k] times w[s][k]), accumulated in 40 bits, shifted right by 15 and saturated to 16 bits. Weight w[s][k] is written at address 64+s*16+k. Speaker s appears at `spk_out[s*16 +: 16]`, and channel c is read from `in_samples[c*16 +: 16]`.
- R5: Configuration writes to addresses 192 to 255 change no gain or weight.
- R6: The valid chain is ordered. An encoder is valid only while the coefficient stage is valid. The summer is valid only while all encoders are valid. A decoder is valid only while the summer is valid.
- R7: A sample pulse clears every stage's valid flag by the next cycle and captures new input samples for the restarted chain.
- R8: On a sample pulse with all decoders valid, `spk_out` takes the results for the samples captured at the previous pulse, and `underrun` goes to 0.
- R9: On a sample pulse with any decoder not valid, `spk_out` holds and `underrun` goes to 1. This includes the first pulse after reset.
- R10: `spk_out` and `underrun` change only in the cycle after a sample pulse.
- R11: Extreme operands saturate rather than wrap. A -32768 sample times a -32768 gain gives 32767, and oversized field sums and speaker accumulations clamp to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_pulse | input | 1 | One-cycle pulse per sample period |
| in_samples | input | 64 | Four signed 16-bit samples, channel c at bits c*16+:16 |
| cfg_wr | input | 1 | Write strobe for gains and weights |
| cfg_addr | input | 8 | Write address (see R2, R4, R5) |
| cfg_data | input | 16 | Signed Q1.15 gain or weight |
| spk_out | output | 128 | Eight signed 16-bit speaker samples, speaker s at bits s*16+:16 |
| underrun | output | 1 | Set when the last pulse found the decoders unfinished |

## Verification
Some behaviour is checked on every cycle by the bound checker:
- the ordering of the valid cascade;
- the clearing of all flags one cycle after a pulse;
- the hold-and-flag reaction to an early pulse;
- the freezing of the outputs between pulses.

The numerical behaviour can only be shown by the bench scenarios comparing against an independent model. This covers the per-channel scaling, the ignored component-0 and out-of-range writes, the field summation, the dot products and saturation at each stage. The same holds for the one-period latency from captured samples to speaker outputs.

// File: rtl/ambi_pkg.sv
// Shared widths and saturation helper for the ambisonic pipeline.
// Assumes samples and gains are signed, gains in Q1.15.
package ambi_pkg;
    localparam int SAMPLE_W = 16;
    localparam int ACC_W    = 40;
    localparam int FRAC     = 15;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    // Clamp a wide signed value into the signed sample range.
    function automatic sample_t sat_sample(input acc_t v);
        acc_t hi;
        acc_t lo;
        hi = acc_t'({1'b0, {(SAMPLE_W-1){1'b1}}});
        lo = ~hi;
        if (v > hi)
            return sample_t'(hi[SAMPLE_W-1:0]);
        else if (v < lo)
            return sample_t'(lo[SAMPLE_W-1:0]);
        else
            return sample_t'(v[SAMPLE_W-1:0]);
    endfunction
endpackage

// File: rtl/ambi_coef_bank.sv
// Register bank holding per-channel encode gains and per-speaker decode
// weights. Encoder gain (ch,k) lives at ch*N_COMP+k, decoder weight (s,k)
// at N_CH*N_COMP + s*N_COMP + k. Component 0 of an encoder is unity, so
// writes to its slot are dropped; addresses past the last weight are dropped.
module ambi_coef_bank
    import ambi_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int N_COMP = 16,
    parameter int N_SPK  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  sample_t           wr_data,
    output sample_t           enc_coef [N_CH][N_COMP],
    output sample_t           dec_w    [N_SPK][N_COMP]
);
    localparam int ENC_N = N_CH * N_COMP;

    for (genvar c = 0; c < N_CH; c++) begin : g_enc_ch
        for (genvar k = 0; k < N_COMP; k++) begin : g_enc_k
            // Store one encoder gain; slot 0 stays zero because it is unused.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    enc_coef[c][k] <= '0;
                else if (wr_en && (k != 0) && (wr_addr == ADDR_W'(c*N_COMP + k)))
                    enc_coef[c][k] <= wr_data;
            end
        end
    end

    for (genvar s = 0; s < N_SPK; s++) begin : g_dec_spk
        for (genvar k = 0; k < N_COMP; k++) begin : g_dec_k
            // Store one decoder weight.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dec_w[s][k] <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(ENC_N + s*N_COMP + k)))
                    dec_w[s][k] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ambi_encoder.sv
// One-channel ambisonic encoder. Once start is high it fills one component
// per cycle with a single multiplier: component 0 copies the sample, others
// are sample*gain >>> FRAC, saturated. valid rises after the last component
// and stays until clear. Assumes start stays high until clear.
module ambi_encoder
    import ambi_pkg::*;
#(
    parameter int N_COMP = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    start,
    input  sample_t sample,
    input  sample_t coef [N_COMP],
    output sample_t comp [N_COMP],
    output logic    valid
);
    localparam int IW = (N_COMP > 1) ? $clog2(N_COMP) : 1;

    logic [IW-1:0]             idx;
    logic signed [2*SAMPLE_W-1:0] prod;
    acc_t                      wide;
    acc_t                      shifted;

    assign prod    = sample * coef[idx];
    assign wide    = acc_t'(prod);
    assign shifted = wide >>> FRAC;

    // Step through the components, writing one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            valid <= 1'b0;
            for (int k = 0; k < N_COMP; k++) comp[k] <= '0;
        end else if (clear) begin
            idx   <= '0;
            valid <= 1'b0;
        end else if (start && !valid) begin
            comp[idx] <= (idx == '0) ? sample : sat_sample(shifted);
            if (idx == IW'(N_COMP-1)) begin
                idx   <= '0;
                valid <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ambi_summer.sv
// Adds the encoded vectors of all channels element by element in one cycle
// once every encoder is valid, saturating each field component.
module ambi_summer
    import ambi_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int N_COMP = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [N_CH-1:0] enc_valid,
    input  sample_t         enc_comp [N_CH][N_COMP],
    output sample_t         field    [N_COMP],
    output logic            valid
);
    acc_t sums [N_COMP];

    // Form the wide per-component sums across channels.
    always_comb begin
        for (int k = 0; k < N_COMP; k++) begin
            sums[k] = '0;
            for (int c = 0; c < N_CH; c++)
                sums[k] = sums[k] + acc_t'(enc_comp[c][k]);
        end
    end

    // Latch the saturated field once all encoders are done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            for (int k = 0; k < N_COMP; k++) field[k] <= '0;
        end else if (clear) begin
            valid <= 1'b0;
        end else if ((&enc_valid) && !valid) begin
            for (int k = 0; k < N_COMP; k++) field[k] <= sat_sample(sums[k]);
            valid <= 1'b1;
        end
    end
endmodule

// File: rtl/ambi_decoder.sv
// One-speaker decoder: dot product of the field with this speaker's weights
// over N_COMP cycles on one multiplier, accumulated in ACC_W bits, then
// shifted by FRAC and saturated. Assumes start stays high until clear.
module ambi_decoder
    import ambi_pkg::*;
#(
    parameter int N_COMP = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    start,
    input  sample_t field  [N_COMP],
    input  sample_t weight [N_COMP],
    output sample_t result,
    output logic    valid
);
    localparam int IW = (N_COMP > 1) ? $clog2(N_COMP) : 1;

    logic [IW-1:0]                idx;
    acc_t                         acc;
    logic signed [2*SAMPLE_W-1:0] prod;
    acc_t                         acc_next;

    assign prod     = field[idx] * weight[idx];
    assign acc_next = acc + acc_t'(prod);

    // Accumulate one product per cycle and finish with a saturated result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            acc    <= '0;
            result <= '0;
            valid  <= 1'b0;
        end else if (clear) begin
            idx   <= '0;
            acc   <= '0;
            valid <= 1'b0;
        end else if (start && !valid) begin
            if (idx == IW'(N_COMP-1)) begin
                result <= sat_sample(acc_next >>> FRAC);
                valid  <= 1'b1;
                idx    <= '0;
            end else begin
                acc <= acc_next;
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ambi_pipeline.sv
// Top of the ambisonic pipeline: coefficient bank, one encoder per channel,
// summer, one decoder per speaker, and the sample-pulse control that clears
// the valid cascade and moves finished results to the outputs. Assumes the
// sample period exceeds the chain latency (about 2*N_COMP+3 cycles) and that
// gains and weights are written while no chain is computing.
module ambi_pipeline
    import ambi_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int N_COMP = 16,
    parameter int N_SPK  = 8,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_pulse,
    input  logic [N_CH*SAMPLE_W-1:0]  in_samples,
    input  logic                      cfg_wr,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [SAMPLE_W-1:0]       cfg_data,
    output logic [N_SPK*SAMPLE_W-1:0] spk_out,
    output logic                      underrun
);
    sample_t          enc_coef [N_CH][N_COMP];
    sample_t          dec_w    [N_SPK][N_COMP];
    sample_t          samp_q   [N_CH];
    sample_t          enc_comp [N_CH][N_COMP];
    sample_t          field    [N_COMP];
    sample_t          dec_res  [N_SPK];
    logic [N_CH-1:0]  enc_valid;
    logic [N_SPK-1:0] dec_valid;
    logic             summing_valid;
    logic             coeffs_valid;
    logic             armed;

    ambi_coef_bank #(
        .N_CH(N_CH), .N_COMP(N_COMP), .N_SPK(N_SPK), .ADDR_W(ADDR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(sample_t'(cfg_data)),
        .enc_coef(enc_coef), .dec_w(dec_w)
    );

    // Capture samples and restart the coefficient stage on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed        <= 1'b0;
            coeffs_valid <= 1'b0;
            for (int c = 0; c < N_CH; c++) samp_q[c] <= '0;
        end else if (sample_pulse) begin
            armed        <= 1'b1;
            coeffs_valid <= 1'b0;
            for (int c = 0; c < N_CH; c++)
                samp_q[c] <= sample_t'(in_samples[c*SAMPLE_W +: SAMPLE_W]);
        end else begin
            coeffs_valid <= armed;
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_enc
        ambi_encoder #(.N_COMP(N_COMP)) u_enc (
            .clk(clk), .rst_n(rst_n), .clear(sample_pulse),
            .start(coeffs_valid), .sample(samp_q[c]), .coef(enc_coef[c]),
            .comp(enc_comp[c]), .valid(enc_valid[c])
        );
    end

    ambi_summer #(.N_CH(N_CH), .N_COMP(N_COMP)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear(sample_pulse),
        .enc_valid(enc_valid), .enc_comp(enc_comp),
        .field(field), .valid(summing_valid)
    );

    for (genvar s = 0; s < N_SPK; s++) begin : g_dec
        ambi_decoder #(.N_COMP(N_COMP)) u_dec (
            .clk(clk), .rst_n(rst_n), .clear(sample_pulse),
            .start(summing_valid), .field(field), .weight(dec_w[s]),
            .result(dec_res[s]), .valid(dec_valid[s])
        );
    end

    // Publish finished speaker samples on a pulse, or hold and flag underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spk_out  <= '0;
            underrun <= 1'b0;
        end else if (sample_pulse) begin
            if (&dec_valid) begin
                for (int s = 0; s < N_SPK; s++)
                    spk_out[s*SAMPLE_W +: SAMPLE_W] <= dec_res[s];
                underrun <= 1'b0;
            end else begin
                underrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ambi_pipeline_checker.sv
// Cycle-level properties of the valid cascade and the output register.
module ambi_pipeline_checker #(
    parameter int N_CH  = 4,
    parameter int N_SPK = 8,
    parameter int OUT_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_pulse,
    input logic             coeffs_valid,
    input logic [N_CH-1:0]  enc_valid,
    input logic             summing_valid,
    input logic [N_SPK-1:0] dec_valid,
    input logic [OUT_W-1:0] spk_out,
    input logic             underrun
);
    assert_enc_after_coef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|enc_valid) |-> coeffs_valid);

    assert_sum_after_enc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        summing_valid |-> (&enc_valid));

    assert_dec_after_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|dec_valid) |-> summing_valid);

    assert_pulse_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |=> (!coeffs_valid && (enc_valid == '0) && !summing_valid && (dec_valid == '0)));

    assert_publish_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pulse && (&dec_valid)) |=> !underrun);

    assert_early_pulse_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pulse && !(&dec_valid)) |=> (underrun && $stable(spk_out)));

    assert_quiet_between_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_pulse |=> ($stable(spk_out) && $stable(underrun)));
endmodule

bind ambi_pipeline ambi_pipeline_checker #(
    .N_CH(N_CH), .N_SPK(N_SPK), .OUT_W(N_SPK*ambi_pkg::SAMPLE_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .sample_pulse(sample_pulse),
    .coeffs_valid(coeffs_valid), .enc_valid(enc_valid),
    .summing_valid(summing_valid), .dec_valid(dec_valid),
    .spk_out(spk_out), .underrun(underrun)
);

// File: tb/ambi_pipeline_test.sv
// Scoreboard bench: the pulse driver pushes the expected outputs for each
// pulse into queues; a monitor pops and compares them after the pulse edge.
module ambi_pipeline_test;
    localparam int NC = 4;
    localparam int NK = 16;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_pulse = 1'b0;
    logic [63:0]   in_samples = '0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [15:0]   cfg_data = '0;
    logic [127:0]  spk_out;
    logic          underrun;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Model state: what the bench believes the gains and weights are.
    longint ec [NC][NK];
    longint dw [NS][NK];

    logic [127:0] exp_out_q [$];
    logic         exp_und_q [$];
    string        tag_q     [$];
    logic [127:0] last_out = '0;
    logic [127:0] pending = '0;
    bit           have_pending = 0;
    bit           pending_ok = 0;
    event         mon_ev;

    always #2 clk = ~clk;

    ambi_pipeline uut (
        .clk(clk), .rst_n(rst_n), .sample_pulse(sample_pulse),
        .in_samples(in_samples), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .spk_out(spk_out), .underrun(underrun)
    );

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Reference model of R2, R3, R4, R11.
    function automatic logic [127:0] model(input logic [63:0] smp);
        longint fld [NK];
        longint s, acc;
        logic [127:0] r;
        for (int k = 0; k < NK; k++) fld[k] = 0;
        for (int c = 0; c < NC; c++) begin
            s = longint'($signed(smp[c*16 +: 16]));
            for (int k = 0; k < NK; k++)
                fld[k] += (k == 0) ? s : sat16((s * ec[c][k]) >>> 15);
        end
        for (int k = 0; k < NK; k++) fld[k] = sat16(fld[k]);
        for (int sp = 0; sp < NS; sp++) begin
            acc = 0;
            for (int k = 0; k < NK; k++) acc += fld[k] * dw[sp][k];
            r[sp*16 +: 16] = 16'(sat16(acc >>> 15));
        end
        return r;
    endfunction

    function automatic logic [63:0] pat(input int n);
        logic [63:0] p;
        for (int c = 0; c < NC; c++) p[c*16 +: 16] = 16'(n*9001 + c*12345 - 7000);
        return p;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Register write; the model follows R2 (slot 0 ignored) and R5 (range).
    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'(addr); cfg_data = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (addr < NC*NK) begin
            if ((addr % NK) != 0) ec[addr/NK][addr%NK] = longint'($signed(data));
        end else if (addr < NC*NK + NS*NK) begin
            dw[(addr-NC*NK)/NK][(addr-NC*NK)%NK] = longint'($signed(data));
        end
    endtask

    // Driver: push the expectation, issue the pulse, wait out the gap.
    task automatic pulse(input logic [63:0] smp, input int gap, input string tag);
        logic [127:0] eo;
        logic eu;
        eu = !(have_pending && pending_ok);
        eo = eu ? last_out : pending;
        exp_out_q.push_back(eo);
        exp_und_q.push_back(eu);
        tag_q.push_back(eu ? {tag, " R9"} : {tag, " R2 R3 R4 R6 R7 R8"});
        last_out = eo;
        pending = model(smp);
        have_pending = 1;
        pending_ok = (gap >= 40);
        @(negedge clk);
        sample_pulse = 1'b1; in_samples = smp;
        @(negedge clk);
        sample_pulse = 1'b0;
        -> mon_ev;
        repeat (gap/2) @(negedge clk);
        // R10: outputs stay put in the middle of the period.
        check("R10 mid-period output", spk_out, eo);
        check("R10 mid-period underrun", 128'(underrun), 128'(eu));
        repeat (gap - gap/2 - 1) @(negedge clk);
    endtask

    // Monitor: pops one expectation per pulse and compares.
    initial begin
        forever begin
            @(mon_ev);
            if (exp_out_q.size() != 0) begin
                logic [127:0] eo;
                logic eu;
                string t;
                eo = exp_out_q.pop_front();
                eu = exp_und_q.pop_front();
                t  = tag_q.pop_front();
                for (int s = 0; s < NS; s++)
                    check({t, " speaker"}, 128'(spk_out[s*16 +: 16]), 128'(eo[s*16 +: 16]));
                check({t, " underrun flag"}, 128'(underrun), 128'(eu));
            end
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) for (int k = 0; k < NK; k++) ec[c][k] = 0;
        for (int s = 0; s < NS; s++) for (int k = 0; k < NK; k++) dw[s][k] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset speakers", spk_out, '0);
        check("R1 reset underrun", 128'(underrun), 128'(0));

        // Gain set A, including slot-0 writes that must be ignored (R2).
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NK; k++)
                wr(c*NK + k, 16'((c*7 + k*3) * 1100 - 26000));
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < NK; k++)
                wr(64 + s*NK + k, 16'(((s*5 + k*11) % 23) * 2500 - 27000));
        // R5: out-of-range writes change nothing.
        wr(192, 16'h7fff);
        wr(200, 16'h8000);
        wr(255, 16'h1234);

        pulse(pat(1), 64, "R9 first pulse");
        pulse(pat(2), 64, "R5");
        pulse(64'h0, 64, "R2");
        pulse(pat(3), 64, "R7");

        // Gain set B: extreme values to force saturation (R11).
        for (int c = 0; c < NC; c++)
            for (int k = 1; k < NK; k++)
                wr(c*NK + k, 16'h8000);
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < NK; k++)
                wr(64 + s*NK + k, (s % 2 == 0) ? 16'h7fff : 16'h8000);
        pulse({4{16'h8000}}, 64, "R11");
        pulse(pat(4), 64, "R11");

        // Early pulse: underrun and hold, then recovery.
        pulse(pat(5), 8, "R11");
        pulse(pat(6), 64, "R9 early");
        pulse(pat(7), 64, "R8 recovery");
        pulse(pat(8), 64, "R8");
        pulse(pat(9), 64, "R8");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual not finished, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule